// File: doc/BRIEF.md
# ADC Conversion Control/Status Register

A byte-wide control and status register that sits between a CPU bus and one converter channel group. It stores the converter set-up: interrupt enable, start, scan/single mode, clock select and a two-bit channel field. Those fields drive the converter sequencer directly. It also holds a conversion-end flag, which the sequencer sets. When the flag and the interrupt enable are both 1, the block raises an interrupt request.

The block guards against an accidental flag clear. Software can clear the flag only by reading the register while the flag is 1 and then writing 0 to that bit. Any write in between cancels that pending read. A DMA acknowledge can also clear the flag. Power-on reset and standby both return the register to zero. A manual reset leaves every stored bit as it is.

Top module: `adc_csr`

## Requirements
- R1: While `rst_ni` is low, the read value is 0x00 and `irq_o` is 0.
- R2: One clock edge with `standby_i` high returns the read value to 0x00 and drives all control outputs to 0. Standby has priority over every other input.
- R3: `man_rst_i` changes no register bit. It cancels a pending read of the end flag as 1, so a following write of 0 does not clear the flag.
- R4: In single mode (bit 4 = 0), `conv_done_i` sets the end flag (bit 7) and `scan_last_i` is ignored.
- R5: In scan mode (bit 4 = 1), only `scan_last_i` sets the end flag and `conv_done_i` is ignored.
- R6: A write with bit 7 = 0 clears the end flag only if the register was read with the flag at 1 before that write. A write with bit 7 = 1 never sets the flag.
- R7: Any write, including one that leaves the flag at 1, cancels a pending read of the flag as 1.
- R8: `dma_clr_i` clears the end flag one edge later, with no read needed.
- R9: When a set event and a clear (write or `dma_clr_i`) arrive in the same cycle, the flag ends at 1.
- R10: `irq_o` is 1 exactly while bit 7 and bit 6 (interrupt enable) both read 1.
- R11: Bit 2 always reads 0, and writing 1 to it has no effect.
- R12: Bits 6, 5, 4, 3 and 1:0 are read/write storage. They drive `irq` gating, `start_o`, `scan_o`, `cks_o` and `chan_o`. `start_clr_i` clears bit 5, but a CPU write in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| standby_i | input | 1 | Standby entry, synchronous clear |
| man_rst_i | input | 1 | Manual reset, leaves contents unchanged |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (register contents) |
| conv_done_i | input | 1 | Single conversion complete pulse |
| scan_last_i | input | 1 | Last scan channel complete pulse |
| dma_clr_i | input | 1 | DMA acknowledge, clears end flag |
| start_clr_i | input | 1 | Sequencer clear of the start bit |
| irq_o | output | 1 | Conversion-end interrupt request |
| start_o | output | 1 | Start bit |
| scan_o | output | 1 | Scan mode select |
| cks_o | output | 1 | Clock select |
| chan_o | output | 2 | Channel select |

## Verification
Every register update lands on the first rising edge after the stimulus. The read data, `irq_o` and the control outputs follow that edge combinationally, so each result is due one clock after its input. The bench drives inputs on falling edges and samples at the next falling edge, half a period after the update edge. A read captures the data in the same low phase in which it is issued, before the edge that records the pending read. The bench applies flag sets and clears in the same cycle to check which one takes priority.

// File: rtl/adc_csr_pkg.sv
package adc_csr_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned CHAN_W  = 2;
  localparam int unsigned B_END   = 7;
  localparam int unsigned B_IE    = 6;
  localparam int unsigned B_START = 5;
  localparam int unsigned B_SCAN  = 4;
  localparam int unsigned B_CKS   = 3;
  localparam int unsigned B_RSV   = 2;
  // writable control bits: everything except end flag and reserved bit
  localparam logic [REG_W-1:0] CTRL_MASK =
      ~((REG_W'(1) << B_END) | (REG_W'(1) << B_RSV));
endpackage

// File: rtl/adc_csr_ctrl.sv
module adc_csr_ctrl
  import adc_csr_pkg::*;
#(
  parameter int unsigned W = REG_W,
  parameter logic [W-1:0] MASK = CTRL_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         standby_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         start_clr_i,
  output logic [W-1:0] ctrl_o
);
  logic [W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ctrl_q <= '0;
    else if (standby_i)   ctrl_q <= '0;
    else if (wr_i)        ctrl_q <= wdata_i & MASK;
    else if (start_clr_i) ctrl_q[B_START] <= 1'b0;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/adc_csr_flag.sv
module adc_csr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic standby_i,
  input  logic man_rst_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_end_i,
  input  logic set_i,
  input  logic dma_clr_i,
  output logic flag_o
);
  logic flag_q, seen_q, clr;

  assign clr = dma_clr_i | (wr_i & ~wr_end_i & seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (standby_i) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      if (set_i)    flag_q <= 1'b1;  // set beats clear
      else if (clr) flag_q <= 1'b0;
      if (wr_i || man_rst_i)   seen_q <= 1'b0;
      else if (rd_i && flag_q) seen_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/adc_csr.sv
module adc_csr
  import adc_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              man_rst_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic              conv_done_i,
  input  logic              scan_last_i,
  input  logic              dma_clr_i,
  input  logic              start_clr_i,
  output logic              irq_o,
  output logic              start_o,
  output logic              scan_o,
  output logic              cks_o,
  output logic [CHAN_W-1:0] chan_o
);
  logic [REG_W-1:0] ctrl;
  logic flag, wr, rd, set_evt;

  assign wr = bus_req_i & bus_we_i;
  assign rd = bus_req_i & ~bus_we_i;
  assign set_evt = ctrl[B_SCAN] ? scan_last_i : conv_done_i;

  adc_csr_ctrl #(.W(REG_W), .MASK(CTRL_MASK)) i_ctrl (
    .clk_i, .rst_ni, .standby_i,
    .wr_i(wr), .wdata_i(bus_wdata_i), .start_clr_i, .ctrl_o(ctrl)
  );

  adc_csr_flag i_flag (
    .clk_i, .rst_ni, .standby_i, .man_rst_i,
    .rd_i(rd), .wr_i(wr), .wr_end_i(bus_wdata_i[B_END]),
    .set_i(set_evt), .dma_clr_i, .flag_o(flag)
  );

  assign bus_rdata_o = ctrl | (REG_W'(flag) << B_END);
  assign irq_o   = flag & ctrl[B_IE];
  assign start_o = ctrl[B_START];
  assign scan_o  = ctrl[B_SCAN];
  assign cks_o   = ctrl[B_CKS];
  assign chan_o  = ctrl[CHAN_W-1:0];
endmodule

// File: rtl/adc_csr_chk.sv
module adc_csr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       standby_i,
  input logic       man_rst_i,
  input logic       bus_req_i,
  input logic       bus_we_i,
  input logic       wr_end_i,
  input logic [7:0] bus_rdata_o,
  input logic       conv_done_i,
  input logic       scan_last_i,
  input logic       dma_clr_i,
  input logic       start_clr_i,
  input logic       irq_o
);
  assert_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (bus_rdata_o[7] & bus_rdata_o[6]));

  assert_rsv_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[2] == 1'b0);

  assert_standby_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> bus_rdata_o == 8'h00);

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && (bus_rdata_o[4] ? scan_last_i : conv_done_i)) |=> bus_rdata_o[7]);

  assert_no_false_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_rdata_o[7]) |->
      ($past(bus_rdata_o[4]) ? $past(scan_last_i) : $past(conv_done_i)));

  assert_clear_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_rdata_o[7]) |->
      $past(standby_i || dma_clr_i || (bus_req_i && bus_we_i && !wr_end_i)));

  assert_mrst_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (man_rst_i && !bus_req_i && !standby_i && !start_clr_i && !conv_done_i &&
     !scan_last_i && !dma_clr_i) |=> $stable(bus_rdata_o));
endmodule

bind adc_csr adc_csr_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .standby_i(standby_i), .man_rst_i(man_rst_i),
  .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .wr_end_i(bus_wdata_i[7]),
  .bus_rdata_o(bus_rdata_o), .conv_done_i(conv_done_i), .scan_last_i(scan_last_i),
  .dma_clr_i(dma_clr_i), .start_clr_i(start_clr_i), .irq_o(irq_o)
);

// File: tb/test_adc_csr.sv
module test_adc_csr;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic standby = 0, mrst = 0, req = 0, we = 0;
  logic [7:0] wdata = '0, rdata;
  logic done = 0, last = 0, dma = 0, sclr = 0;
  logic irq, start, scan, cks;
  logic [1:0] chan;
  int n_chk = 0, n_bad = 0;
  logic fin = 0;

  always #4 clk = ~clk;  // 125 MHz

  adc_csr i_adc_csr (
    .clk_i(clk), .rst_ni, .standby_i(standby), .man_rst_i(mrst),
    .bus_req_i(req), .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .conv_done_i(done), .scan_last_i(last), .dma_clr_i(dma), .start_clr_i(sclr),
    .irq_o(irq), .start_o(start), .scan_o(scan), .cks_o(cks), .chan_o(chan)
  );

  task automatic check(string req_id, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req_id, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); req = 1; we = 1; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); req = 1; we = 0; #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic t_reset;
    check("R1 rdata", rdata, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_ctrl;
    wr(8'h7F);
    check("R11 R12 rdata", rdata, 8'h7B);
    check("R12 outputs", {4'b0, start, scan, cks, 1'b0} | {6'b0, chan}, 8'h0F);
    @(negedge clk); sclr = 1; @(negedge clk); sclr = 0;
    check("R12 start_clr", {7'b0, start}, 8'h00);
    @(negedge clk); req = 1; we = 1; wdata = 8'h20; sclr = 1;
    @(negedge clk); req = 0; we = 0; sclr = 0;
    check("R12 write beats start_clr", rdata, 8'h20);
  endtask

  task automatic t_single;
    logic [7:0] d;
    wr(8'h40);
    @(negedge clk); last = 1; @(negedge clk); last = 0;
    check("R4 scan_last ignored in single", rdata, 8'h40);
    @(negedge clk); done = 1; @(negedge clk); done = 0;
    check("R4 flag set", rdata, 8'hC0);
    check("R10 irq on", {7'b0, irq}, 8'h01);
    wr(8'h40);
    check("R6 no clear without read", rdata, 8'hC0);
    rd(d);
    check("R6 read value", d, 8'hC0);
    wr(8'h40);
    check("R6 clear after read", rdata, 8'h40);
    check("R10 irq off", {7'b0, irq}, 8'h00);
    wr(8'hC0);
    check("R6 write 1 no set", rdata, 8'h40);
  endtask

  task automatic t_seen_cancel;
    logic [7:0] d;
    @(negedge clk); done = 1; @(negedge clk); done = 0;
    rd(d);
    wr(8'hC0);
    wr(8'h40);
    check("R7 intervening write cancels read", rdata, 8'hC0);
    rd(d);
    wr(8'h40);
    check("R7 fresh read then clear", rdata, 8'h40);
  endtask

  task automatic t_scan;
    wr(8'h10);
    @(negedge clk); done = 1; @(negedge clk); done = 0;
    check("R5 conv_done ignored in scan", rdata, 8'h10);
    @(negedge clk); last = 1; @(negedge clk); last = 0;
    check("R5 flag on last", rdata, 8'h90);
    check("R10 irq masked", {7'b0, irq}, 8'h00);
    @(negedge clk); dma = 1; @(negedge clk); dma = 0;
    check("R8 dma clear", rdata, 8'h10);
  endtask

  task automatic t_set_wins;
    logic [7:0] d;
    @(negedge clk); last = 1; @(negedge clk); last = 0;
    rd(d);
    @(negedge clk); req = 1; we = 1; wdata = 8'h10; last = 1;
    @(negedge clk); req = 0; we = 0; last = 0;
    check("R9 set beats write clear", rdata, 8'h90);
    @(negedge clk); dma = 1; last = 1;
    @(negedge clk); dma = 0; last = 0;
    check("R9 set beats dma clear", rdata, 8'h90);
  endtask

  task automatic t_mrst;
    logic [7:0] d;
    wr(8'h3D);  // flag still 1, seen dropped by write
    rd(d);
    @(negedge clk); mrst = 1; @(negedge clk); mrst = 0;
    check("R3 contents held", rdata, 8'hB9);
    wr(8'h39);
    check("R3 read cancelled", rdata, 8'hB9);
  endtask

  task automatic t_standby;
    @(negedge clk); standby = 1; done = 1; @(negedge clk); standby = 0; done = 0;
    check("R2 standby clear", rdata, 8'h00);
    check("R2 outputs", {4'b0, start, scan, cks, 1'b0} | {6'b0, chan}, 8'h00);
  endtask

  task automatic t_por;
    wr(8'h7B);
    @(negedge clk); rst_ni = 0; #1;
    check("R1 async reset", rdata, 8'h00);
    @(negedge clk); rst_ni = 1;
  endtask

  initial begin
    #1 t_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1;
    t_ctrl();
    t_single();
    t_seen_cancel();
    t_scan();
    t_set_wins();
    t_mrst();
    t_standby();
    t_por();
    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule